// File: doc/BRIEF.md
# Embedded Program and Chip-Erase Sequencer

This block carries out the internal write algorithms of a small flash-style storage array once a command front end has decoded a complete command and pulses `start`. Two operations exist: a single-word program and a full chip erase. Programming follows the flash rule that bits can only move from 1 to 0. The stored word becomes the old word ANDed with the supplied data. A request to raise a stored 0 back to 1 is reported on an error output.

A chip erase runs in two passes over the array. The first pass drives every word to zero, from the lowest address to the highest. The second pass returns every word to all ones. Each step of either operation lasts a programmable number of clock cycles. This lets a host poll the block while it is busy. During that time a read returns a status word and not array contents. The status word holds a data-polling bit, which is the complement of the target MSB, and a bit that flips on every status read. The ready output stays low for the whole operation. A synchronous hardware reset abandons any operation at once.

Top module: `flash_algo_ctrl`

## Requirements
- R1: After reset is released, `ready` is 1 and `err` is 0. Holding `rst_n` low during an operation ends it, and `ready` reads 1 on the cycle after the reset edge.
- R2: A program operation leaves the addressed word equal to its previous value AND the supplied data. A stored 0 stays 0 whatever data is given. Programs may target any address in any order.
- R3: When a program's data has a 1 where the stored word has a 0, `err` goes to 1 as the operation completes. `err` returns to 0 when the next operation is accepted.
- R4: An accepted program holds `ready` low for exactly L cycles, where L is `step_cycles`. `ready` reads 1 again L cycles after the start edge.
- R5: A chip erase holds `ready` low for 2·DEPTH·L cycles. After it, every word reads all ones.
- R6: A chip erase first zeroes every word in ascending address order, one word per step, and only then starts erasing. A reset after DEPTH·L cycles and before the next step ends leaves every word at 0.
- R7: A read while busy returns a status word. In it, bit 7 is the complement of the target data's MSB: the program data's MSB, or 1 for an erase, so bit 7 reads 0. Bit 5 is 0 and bits 4..0 are 0. The value appears on `rd_data` one cycle after `rd_en`.
- R8: Bit 6 of the status word takes opposite values on two successive busy reads.
- R9: A `start` pulse while busy is ignored. It changes neither the running operation's result nor its duration, and it leaves the word it names untouched.
- R10: A read while idle returns the stored word at `rd_addr` on `rd_data` one cycle after `rd_en`.
- R11: A `step_cycles` value of 0 is handled as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| start | input | 1 | One-cycle request from the command decoder |
| op | input | 1 | 0 = program word, 1 = chip erase |
| addr | input | ADDR_W | Program target address |
| wdata | input | DATA_W | Program data |
| step_cycles | input | CNT_W | Cycles per algorithm step (0 acts as 1) |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array word when idle, status word when busy |
| ready | output | 1 | 1 = idle, 0 = algorithm running |
| err | output | 1 | Program tried to raise a stored 0 |

## Verification
Let E0 be the clock edge at which `start` is sampled. `ready` drops at E0. It rises at E0+L for a program, and at E0+2·DEPTH·L for an erase. `err` changes at the same edge at which `ready` rises. `rd_data` is registered, so it is due one edge after the edge that samples `rd_en`. The bench drives inputs and samples outputs on falling edges. After deasserting `start`, it counts falling edges until `ready` is seen high and expects exactly L+1. It reads a result on the falling edge that follows the one on which `rd_en` was raised. The abort check raises reset so that the reset is sampled at E0+DEPTH·L+1. That edge falls between the last zeroing write and the first erase write.

// File: rtl/flash_algo_pkg.sv
// Shared definitions for the program/erase sequencer.
// Assumes data words of at least 8 bits (status bits sit in the low byte).
package flash_algo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ZERO  = 2'd2,
        ST_ERASE = 2'd3
    } algo_state_e;

    typedef enum logic {
        OP_PROGRAM    = 1'b0,
        OP_CHIP_ERASE = 1'b1
    } algo_op_e;

    // Status word bit positions; the host's polling routine depends on them.
    localparam int unsigned STAT_POLL_BIT   = 7;
    localparam int unsigned STAT_TOGGLE_BIT = 6;
    localparam int unsigned STAT_FAIL_BIT   = 5;

endpackage

// File: rtl/step_timer.sv
// Counts the cycles of one algorithm step.
// Assumes: restart is asserted on the cycle an operation is accepted;
// a limit of 0 is treated as 1.
module step_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             step_done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_limit;

    // Effective step length, never zero.
    always_comb eff_limit = (limit == '0) ? ONE : limit;

    assign step_done = run && (cnt_q == eff_limit - ONE);

    // Step cycle counter, cleared at each step boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (restart || step_done) cnt_q <= '0;
        else if (run)                  cnt_q <= cnt_q + ONE;
    end

    // The counter never passes the end of a step (R11 keeps the window nonzero).
    assert_cnt_in_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < eff_limit));

endmodule

// File: rtl/flash_array.sv
// Register-based storage array with one write port and two read ports.
// Writes either AND the data into the word (program/zeroing) or overwrite
// it (erase to ones). Contents are not reset, as in real non-volatile storage.
module flash_array #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_and,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q,
    output logic [DATA_W-1:0] tgt_q
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_q  = mem[rd_addr];
    assign tgt_q = mem[wr_addr];

    // Word update: clear-only merge or full overwrite.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_and) mem[wr_addr] <= mem[wr_addr] & wr_data;
            else        mem[wr_addr] <= wr_data;
        end
    end

    // A clear-only write never raises a bit of the target word.
    assert_no_bit_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_and) |=> ((mem[$past(wr_addr)] & ~$past(tgt_q)) == '0));

endmodule

// File: rtl/algo_fsm.sv
// Sequencer for word program and two-pass chip erase.
// Assumes step_done pulses once per step from the step timer and that
// start is a single-cycle pulse; start is ignored unless idle.
module algo_fsm
    import flash_algo_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step_done,
    input  logic [DATA_W-1:0] tgt_q,
    output logic              busy,
    output logic              accept,
    output logic              wr_en,
    output logic              wr_and,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              poll_bit,
    output logic              err
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [ADDR_W-1:0] A_ONE     = ADDR_W'(1);

    algo_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] walk_q;
    logic              err_q;

    assign busy   = (state_q != ST_IDLE);
    assign accept = start && !busy;
    assign err    = err_q;

    // Write port steering for the current phase.
    always_comb begin
        wr_en   = busy && step_done;
        wr_and  = (state_q != ST_ERASE);
        wr_addr = (state_q == ST_PROG) ? addr_q : walk_q;
        unique case (state_q)
            ST_PROG:  wr_data = data_q;
            ST_ZERO:  wr_data = '0;
            default:  wr_data = '1;
        endcase
    end

    // Data-polling bit: complement of the target MSB (erase target is all ones).
    always_comb poll_bit = (state_q == ST_PROG) ? ~data_q[DATA_W-1] : 1'b0;

    // Phase sequencing and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            walk_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q  <= 1'b0;
                        addr_q <= addr;
                        data_q <= wdata;
                        walk_q <= '0;
                        state_q <= (algo_op_e'(op) == OP_PROGRAM) ? ST_PROG : ST_ZERO;
                    end
                end
                ST_PROG: begin
                    if (step_done) begin
                        err_q   <= |(data_q & ~tgt_q);
                        state_q <= ST_IDLE;
                    end
                end
                ST_ZERO: begin
                    if (step_done) begin
                        walk_q <= walk_q + A_ONE;
                        if (walk_q == LAST_ADDR) state_q <= ST_ERASE;
                    end
                end
                ST_ERASE: begin
                    if (step_done) begin
                        walk_q <= walk_q + A_ONE;
                        if (walk_q == LAST_ADDR) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // A start while busy leaves the captured operands alone.
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(addr_q) && $stable(data_q)));

    // The error flag only rises as a program step finishes.
    assert_err_from_program_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> ($past(state_q) == ST_PROG));

    // Erase pass starts only after the zeroing pass covered the last word.
    assert_zero_before_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && $past(state_q) == ST_ZERO) |-> ($past(walk_q) == LAST_ADDR));

endmodule

// File: rtl/status_read.sv
// Registered read path: array word when idle, polling status word when busy.
// Assumes DATA_W >= 8. The toggle bit flips on every busy read.
module status_read
    import flash_algo_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  logic              poll_bit,
    input  logic              fail_bit,
    input  logic [DATA_W-1:0] arr_q,
    output logic [DATA_W-1:0] rd_data
);
    logic              tog_q;
    logic [DATA_W-1:0] stat_word;

    // Assemble the status word from its individual bits.
    always_comb begin
        stat_word                  = '0;
        stat_word[STAT_POLL_BIT]   = poll_bit;
        stat_word[STAT_TOGGLE_BIT] = tog_q;
        stat_word[STAT_FAIL_BIT]   = fail_bit;
    end

    // Read register and toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rd_data <= stat_word;
                tog_q   <= ~tog_q;
            end else begin
                rd_data <= arr_q;
            end
        end
    end

    // Two back-to-back busy reads return opposite toggle bits.
    assert_toggle_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && $past(rd_en && busy)) |=>
            (rd_data[STAT_TOGGLE_BIT] != $past(rd_data[STAT_TOGGLE_BIT])));

endmodule

// File: rtl/flash_algo_ctrl.sv
// Top of the embedded program / chip-erase sequencer.
// Connects step timer, sequencer, storage array and read path.
// Assumes start comes from a command decoder as a one-cycle pulse.
module flash_algo_ctrl #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  step_cycles,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic              err
);
    logic              busy;
    logic              accept;
    logic              step_done;
    logic              wr_en;
    logic              wr_and;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] tgt_q;
    logic              poll_bit;

    assign ready = !busy;

    step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (accept),
        .run       (busy),
        .limit     (step_cycles),
        .step_done (step_done)
    );

    algo_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .addr      (addr),
        .wdata     (wdata),
        .step_done (step_done),
        .tgt_q     (tgt_q),
        .busy      (busy),
        .accept    (accept),
        .wr_en     (wr_en),
        .wr_and    (wr_and),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .poll_bit  (poll_bit),
        .err       (err)
    );

    flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_and  (wr_and),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_q    (rd_q),
        .tgt_q   (tgt_q)
    );

    status_read #(.DATA_W(DATA_W)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .busy     (busy),
        .poll_bit (poll_bit),
        .fail_bit (err),
        .arr_q    (rd_q),
        .rd_data  (rd_data)
    );

    // An accepted start drops ready on the next cycle.
    assert_start_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    // Leaving reset always finds the block idle.
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (ready && !err));

endmodule

// File: tb/tb_flash_algo_ctrl.sv
module tb_flash_algo_ctrl;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              op = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [CNT_W-1:0]  step_cycles = 8'd2;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              ready;
    logic              err;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_algo_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
        .wdata(wdata), .step_cycles(step_cycles), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready), .err(err)
    );

    // Program vectors: {addr, data, expected word, expected err}.
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {4'd3,  8'hA5, 8'hA5, 1'b0},
        {4'd3,  8'hF0, 8'hA0, 1'b1},
        {4'd3,  8'h20, 8'h20, 1'b0},
        {4'd15, 8'h00, 8'h00, 1'b0},
        {4'd0,  8'hFF, 8'hFF, 1'b0},
        {4'd7,  8'h3C, 8'h3C, 1'b0},
        {4'd7,  8'hC3, 8'h00, 1'b1},
        {4'd8,  8'h81, 8'h81, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue an operation and count falling edges until ready is seen high.
    task automatic run_op(input logic o, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] l,
                          output int n);
        @(negedge clk);
        op = o; addr = a; wdata = d; step_cycles = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!ready && n < 100000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic read_word(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] q);
        rd_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        logic [DATA_W-1:0] q, q2;
        bit all_ok;

        do_reset();
        chk("R1 ready after reset", 32'(ready), 1);
        chk("R1 err after reset", 32'(err), 0);

        // R5: full chip erase timing and contents.
        run_op(1'b1, '0, '0, 8'd2, n);
        chk("R5 erase ready-low cycles", n, 2*DEPTH*2 + 1);
        @(negedge clk);
        all_ok = 1;
        for (int i = 0; i < DEPTH; i++) begin
            read_word(ADDR_W'(i), q);
            if (q !== 8'hFF) all_ok = 0;
        end
        chk("R5 all words erased", 32'(all_ok), 1);

        // Vector walk: R2 AND-merge, R3 error flag, R4 timing, R10 idle reads.
        for (int v = 0; v < NV; v++) begin
            run_op(1'b0, VEC[v][20:17], VEC[v][16:9], 8'd3, n);
            chk("R4 program ready-low cycles", n, 4);
            chk("R3 err after program", 32'(err), 32'(VEC[v][0]));
            read_word(VEC[v][20:17], q);
            chk("R2 R10 stored word", 32'(q), 32'(VEC[v][8:1]));
        end

        // R11: zero step length behaves as one.
        run_op(1'b0, 4'd1, 8'hFE, 8'd0, n);
        chk("R11 step of zero acts as one", n, 2);
        read_word(4'd1, q);
        chk("R11 program with zero step", 32'(q), 32'hFE);

        // R9: start while busy is ignored.
        @(negedge clk);
        op = 1'b0; addr = 4'd10; wdata = 8'h5A; step_cycles = 8'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        repeat (2) begin @(negedge clk); n++; end
        addr = 4'd5; wdata = 8'h00; start = 1'b1;
        @(negedge clk); n++;
        start = 1'b0;
        while (!ready && n < 100000) begin @(negedge clk); n++; end
        chk("R9 duration unchanged", n, 11);
        read_word(4'd10, q);
        chk("R9 running op result", 32'(q), 32'h5A);
        read_word(4'd5, q);
        chk("R9 ignored target untouched", 32'(q), 32'hFF);

        // R7/R8: status reads while a program runs (target MSB 0 -> bit7 = 1).
        @(negedge clk);
        op = 1'b0; addr = 4'd9; wdata = 8'h12; step_cycles = 8'd20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        read_word(4'd9, q);
        read_word(4'd9, q2);
        chk("R7 program poll bit7", 32'(q[7]), 1);
        chk("R7 status low bits", 32'({q[5:0]}), 0);
        chk("R8 toggle flips", 32'(q[6] ^ q2[6]), 1);
        while (!ready) @(negedge clk);
        read_word(4'd9, q);
        chk("R10 true data after program", 32'(q), 32'h12);

        // R7: status during erase reads bit7 = 0.
        @(negedge clk);
        op = 1'b1; step_cycles = 8'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        read_word(4'd0, q);
        chk("R7 erase poll bit7", 32'(q[7]), 0);
        chk("R7 erase status low bits", 32'({q[5:0]}), 0);
        while (!ready) @(negedge clk);
        chk("R3 err cleared by next op", 32'(err), 0);

        // R1: reset aborts a running program.
        @(negedge clk);
        op = 1'b0; addr = 4'd2; wdata = 8'h00; step_cycles = 8'd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 busy before abort", 32'(ready), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ready after abort", 32'(ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset right after the zeroing pass leaves all words at 0.
        @(negedge clk);
        op = 1'b1; step_cycles = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (DEPTH*2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        all_ok = 1;
        for (int i = 0; i < DEPTH; i++) begin
            read_word(ADDR_W'(i), q);
            if (q !== 8'h00) all_ok = 0;
        end
        chk("R6 zeroing pass complete", 32'(all_ok), 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule